// File: doc/BRIEF.md
# Half-Bridge Driver Fault Supervisor

This block is the digital fault manager of a multi-channel half-bridge motor driver. It takes synchronous comparator flags for supply undervoltage, supply overvoltage at two thresholds, over-temperature warning and shutdown, and per-channel flags for overcurrent, active open-load and passive open-load. From these flags it drives three outputs: an active-low fault pin, a status word with one bit per fault, and a per-channel request that puts each half-bridge into Hi-Z.

Each fault class has its own recovery policy. Supply, overvoltage and thermal faults recover on their own as soon as the flag drops. Overcurrent and open-load faults latch, and only a clear-fault strobe releases them, and only once their condition has gone away. For passive open-load, a fresh detection sequence must also have finished. Configuration inputs decide, separately for each fault class, whether the fault pulls the fault pin low and whether the bridge keeps running.

Every output is a combinational function of the live flags and the latch state, so a newly raised flag shows up in the same cycle. A latch holds a fault from the first clock edge at which its flag is seen. The reset input is the logic power-on reset. The block has no data stream, so it has no valid/ready interface: every pin is a plain level or a single-cycle strobe.

Top module: `fault_supervisor`

## Requirements
- R1: While `uv_i` is 1, every `hiz_o` bit is 1, `fault_n_o` is 0 and status bit 1 is set. All three return to normal in the cycle `uv_i` drops, with no clear-fault.
- R2: While `rst_n` is 0, every `hiz_o` bit is 1 and `fault_n_o` is 1. After reset, status bit 2 (power-on flag) reads 1 and keeps reading 1 until the first `clr_i` pulse. This bit never drives the fault pin.
- R3: The overvoltage flag in use is `ov_hi_i` when `cfg_ov_hi_sel` is 1 and `ov_lo_i` when it is 0. The other flag has no effect. The flag in use forces all bridges to Hi-Z, drives the pin low and sets status bit 3, and all of this recovers automatically.
- R4: An overcurrent flag on channel k forces `hiz_o[k]` and sets status bit 6+k. Both stay set after the flag drops, until a `clr_i` pulse arrives while the flag is 0.
- R5: Overcurrent drives `fault_n_o` low only when `cfg_oc_pin_en` is 1.
- R6: Active open-load on channel k sets status bit 6+N+k and latches in the same way as R4. It drives `fault_n_o` low only when `cfg_ol_pin_mask` is 0.
- R7: When `cfg_ol_keep_run` is 0, an active open-load forces `hiz_o[k]`. When it is 1, the channel keeps running.
- R8: Passive open-load on channel k sets status bit 6+2N+k and never forces Hi-Z. The pin follows the rule in R6. It clears only on a `clr_i` pulse that arrives while the flag is 0 and after at least one `olp_seq_done_i` pulse since the fault latched.
- R9: The over-temperature warning never forces Hi-Z. It always follows `otw_i` in status bit 4, and it drives `fault_n_o` low only when `cfg_otw_pin_en` is 1.
- R10: While `otsd_i` is 1, all bridges are in Hi-Z, the pin is low and status bit 5 is set. All of this recovers in the cycle the flag drops.
- R11: Status bit 0 is the OR of all other status bits. `fault_n_o` is low exactly when at least one pin-enabled fault is active.
- R12: A `clr_i` pulse in a cycle where a latched fault's flag is still 1 leaves that fault latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Logic power-on reset, active low, asynchronous |
| cfg_ov_hi_sel | input | 1 | 1 selects the high overvoltage threshold |
| cfg_oc_pin_en | input | 1 | 1 lets overcurrent drive the fault pin |
| cfg_ol_pin_mask | input | 1 | 1 keeps open-load faults off the fault pin |
| cfg_ol_keep_run | input | 1 | 1 keeps a channel running on active open-load |
| cfg_otw_pin_en | input | 1 | 1 lets the temperature warning drive the fault pin |
| clr_i | input | 1 | Single-cycle clear-fault strobe |
| uv_i | input | 1 | Supply undervoltage flag |
| ov_lo_i | input | 1 | Overvoltage flag, low threshold |
| ov_hi_i | input | 1 | Overvoltage flag, high threshold |
| otw_i | input | 1 | Over-temperature warning flag (hysteresis applied upstream) |
| otsd_i | input | 1 | Over-temperature shutdown flag (hysteresis applied upstream) |
| oc_i | input | N_CH | Per-channel overcurrent flags |
| ola_i | input | N_CH | Per-channel active open-load flags |
| olp_i | input | N_CH | Per-channel passive open-load flags |
| olp_seq_done_i | input | 1 | Pulse at the end of a passive open-load sequence |
| fault_n_o | output | 1 | Fault pin, active low |
| stat_o | output | 6+3*N_CH | Status word, layout as given in the requirements |
| hiz_o | output | N_CH | Per-channel Hi-Z request |

## Verification
The hardest case to reach is the passive open-load release, because three events have to line up. The latch must already hold, the sequence-done pulse must land at a clock edge while the latch is still set, and only a later clear strobe may release it. The stimulus first issues a clear with no sequence and checks that the fault stays latched. It then pulses sequence-done on its own and checks again, and only after that issues the clear that releases the latch. A second hard case is a clear that coincides with a flag still present. The bench keeps the overcurrent flag high across the clear edge, drops it at the next negative edge and confirms that the fault is still latched.

// File: rtl/fs_pkg.sv
package fs_pkg;
  // Status word bit positions; per-channel fields start at ST_CH_BASE.
  localparam int ST_ANY     = 0;
  localparam int ST_UV      = 1;
  localparam int ST_POR     = 2;
  localparam int ST_OV      = 3;
  localparam int ST_OTW     = 4;
  localparam int ST_OTSD    = 5;
  localparam int ST_CH_BASE = 6;

  function automatic int stat_width(input int n_ch);
    return ST_CH_BASE + 3 * n_ch;
  endfunction
endpackage

// File: rtl/fs_chan_latch.sv
// Per-channel sticky fault: sets on the flag, releases only on clear while the flag is low.
module fs_chan_latch #(
  parameter int N_CH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [N_CH-1:0] flag,
  output logic [N_CH-1:0] held
);
  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    logic lat_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            lat_q <= 1'b0;
      else if (flag[k])      lat_q <= 1'b1;
      else if (clr)          lat_q <= 1'b0;
    end
    assign held[k] = lat_q | flag[k];
  end
endmodule

// File: rtl/fs_olp_tracker.sv
// Passive open-load: release needs a completed sequence since latching, then a clear with flag low.
module fs_olp_tracker #(
  parameter int N_CH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            seq_done,
  input  logic [N_CH-1:0] flag,
  output logic [N_CH-1:0] held
);
  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    logic lat_q, seq_q, lat_d;
    always_comb begin
      lat_d = lat_q;
      if (flag[k])               lat_d = 1'b1;
      else if (clr && seq_q)     lat_d = 1'b0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lat_q <= 1'b0;
        seq_q <= 1'b0;
      end else begin
        lat_q <= lat_d;
        if (!lat_d)        seq_q <= 1'b0;
        else if (seq_done) seq_q <= 1'b1;
      end
    end
    assign held[k] = lat_q | flag[k];
  end
endmodule

// File: rtl/fs_combine.sv
// Maps active faults onto the pin, the status word and the Hi-Z requests.
module fs_combine
  import fs_pkg::*;
#(
  parameter int N_CH = 4,
  localparam int SW  = stat_width(N_CH)
) (
  input  logic            rst_n,
  input  logic            cfg_ov_hi_sel,
  input  logic            cfg_oc_pin_en,
  input  logic            cfg_ol_pin_mask,
  input  logic            cfg_ol_keep_run,
  input  logic            cfg_otw_pin_en,
  input  logic            uv,
  input  logic            ov_lo,
  input  logic            ov_hi,
  input  logic            otw,
  input  logic            otsd,
  input  logic            por,
  input  logic [N_CH-1:0] oc_h,
  input  logic [N_CH-1:0] ola_h,
  input  logic [N_CH-1:0] olp_h,
  output logic            fault_n,
  output logic [SW-1:0]   stat,
  output logic [N_CH-1:0] hiz
);
  logic ov, all_off, pin_req;
  logic [SW-1:0] raw;

  always_comb begin
    ov      = cfg_ov_hi_sel ? ov_hi : ov_lo;
    all_off = uv | ov | otsd | ~rst_n;
    hiz     = {N_CH{all_off}} | oc_h | (ola_h & {N_CH{~cfg_ol_keep_run}});

    pin_req = uv | ov | otsd
            | (otw & cfg_otw_pin_en)
            | ((|oc_h) & cfg_oc_pin_en)
            | ((|ola_h | |olp_h) & ~cfg_ol_pin_mask);
    fault_n = ~(pin_req & rst_n);

    raw                                = '0;
    raw[ST_UV]                         = uv;
    raw[ST_POR]                        = por;
    raw[ST_OV]                         = ov;
    raw[ST_OTW]                        = otw;
    raw[ST_OTSD]                       = otsd;
    raw[ST_CH_BASE +: N_CH]            = oc_h;
    raw[ST_CH_BASE + N_CH +: N_CH]     = ola_h;
    raw[ST_CH_BASE + 2*N_CH +: N_CH]   = olp_h;
    raw[ST_ANY]                        = |raw;
    stat                               = raw;
  end
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fs_pkg::*;
#(
  parameter int N_CH = 4,
  localparam int SW  = stat_width(N_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_ov_hi_sel,
  input  logic            cfg_oc_pin_en,
  input  logic            cfg_ol_pin_mask,
  input  logic            cfg_ol_keep_run,
  input  logic            cfg_otw_pin_en,
  input  logic            clr_i,
  input  logic            uv_i,
  input  logic            ov_lo_i,
  input  logic            ov_hi_i,
  input  logic            otw_i,
  input  logic            otsd_i,
  input  logic [N_CH-1:0] oc_i,
  input  logic [N_CH-1:0] ola_i,
  input  logic [N_CH-1:0] olp_i,
  input  logic            olp_seq_done_i,
  output logic            fault_n_o,
  output logic [SW-1:0]   stat_o,
  output logic [N_CH-1:0] hiz_o
);
  logic            por_q;
  logic [N_CH-1:0] oc_h, ola_h, olp_h;

  // Power-on marker: set by reset, released by the first clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     por_q <= 1'b1;
    else if (clr_i) por_q <= 1'b0;
  end

  fs_chan_latch #(.N_CH(N_CH)) u_oc (
    .clk(clk), .rst_n(rst_n), .clr(clr_i), .flag(oc_i), .held(oc_h));

  fs_chan_latch #(.N_CH(N_CH)) u_ola (
    .clk(clk), .rst_n(rst_n), .clr(clr_i), .flag(ola_i), .held(ola_h));

  fs_olp_tracker #(.N_CH(N_CH)) u_olp (
    .clk(clk), .rst_n(rst_n), .clr(clr_i), .seq_done(olp_seq_done_i),
    .flag(olp_i), .held(olp_h));

  fs_combine #(.N_CH(N_CH)) u_comb (
    .rst_n(rst_n),
    .cfg_ov_hi_sel(cfg_ov_hi_sel), .cfg_oc_pin_en(cfg_oc_pin_en),
    .cfg_ol_pin_mask(cfg_ol_pin_mask), .cfg_ol_keep_run(cfg_ol_keep_run),
    .cfg_otw_pin_en(cfg_otw_pin_en),
    .uv(uv_i), .ov_lo(ov_lo_i), .ov_hi(ov_hi_i), .otw(otw_i), .otsd(otsd_i),
    .por(por_q), .oc_h(oc_h), .ola_h(ola_h), .olp_h(olp_h),
    .fault_n(fault_n_o), .stat(stat_o), .hiz(hiz_o));
endmodule

// File: rtl/fault_supervisor_chk.sv
module fault_supervisor_chk
  import fs_pkg::*;
#(
  parameter int N_CH = 4,
  localparam int SW  = stat_width(N_CH)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_ov_hi_sel,
  input logic            cfg_ol_keep_run,
  input logic            clr_i,
  input logic            uv_i,
  input logic            ov_lo_i,
  input logic            ov_hi_i,
  input logic            otsd_i,
  input logic [N_CH-1:0] oc_i,
  input logic            fault_n_o,
  input logic [SW-1:0]   stat_o,
  input logic [N_CH-1:0] hiz_o
);
  logic [N_CH-1:0] oc_st, olp_st;
  assign oc_st  = stat_o[ST_CH_BASE +: N_CH];
  assign olp_st = stat_o[ST_CH_BASE + 2*N_CH +: N_CH];

  a_r1_uv_off: assert property (@(posedge clk) disable iff (!rst_n)
    uv_i |-> ((&hiz_o) && !fault_n_o && stat_o[ST_UV]));

  always @(posedge clk)
    if (!rst_n) a_r2_reset_safe: assert ((&hiz_o) && fault_n_o);

  a_r3_ov_select: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ov_hi_sel ? ov_hi_i : ov_lo_i) |-> ((&hiz_o) && !fault_n_o && stat_o[ST_OV]));

  a_r4_oc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((oc_st & $past(oc_st)) == $past(oc_st)));

  a_r4_oc_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_st != '0) |-> ((hiz_o & oc_st) == oc_st));

  a_r8_olp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((olp_st & $past(olp_st)) == $past(olp_st)));

  a_r7_keep_run: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ol_keep_run && oc_st == '0 && !uv_i && !otsd_i &&
     !(cfg_ov_hi_sel ? ov_hi_i : ov_lo_i)) |-> (hiz_o == '0));

  a_r11_any_or: assert property (@(posedge clk) disable iff (!rst_n)
    stat_o[ST_ANY] == (|stat_o[SW-1:1]));

  a_r12_clr_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> ((oc_st & $past(oc_i)) == $past(oc_i)));
endmodule

bind fault_supervisor fault_supervisor_chk #(.N_CH(N_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_ov_hi_sel(cfg_ov_hi_sel),
  .cfg_ol_keep_run(cfg_ol_keep_run), .clr_i(clr_i), .uv_i(uv_i),
  .ov_lo_i(ov_lo_i), .ov_hi_i(ov_hi_i), .otsd_i(otsd_i), .oc_i(oc_i),
  .fault_n_o(fault_n_o), .stat_o(stat_o), .hiz_o(hiz_o));

// File: tb/fault_supervisor_bench.sv
module fault_supervisor_bench;
  localparam int N  = 4;
  localparam int SW = 6 + 3*N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_ov_hi_sel = 0, cfg_oc_pin_en = 0, cfg_ol_pin_mask = 0;
  logic cfg_ol_keep_run = 0, cfg_otw_pin_en = 0;
  logic clr_i = 0, uv_i = 0, ov_lo_i = 0, ov_hi_i = 0, otw_i = 0, otsd_i = 0;
  logic [N-1:0] oc_i = '0, ola_i = '0, olp_i = '0;
  logic olp_seq_done_i = 0;
  logic fault_n_o;
  logic [SW-1:0] stat_o;
  logic [N-1:0] hiz_o;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  fault_supervisor #(.N_CH(N)) u_fault_supervisor (.*);

  function automatic int mk(bit uv, bit por, bit ov, bit otw, bit otsd,
                            int oc, int ola, int olp);
    int v;
    v = (int'(uv) << 1) | (int'(por) << 2) | (int'(ov) << 3) |
        (int'(otw) << 4) | (int'(otsd) << 5) |
        (oc << 6) | (ola << (6+N)) | (olp << (6+2*N));
    if (v != 0) v = v | 1;
    return v;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic outs(string tag, int st, int hz, bit pin);
    #1;
    chk({tag, " status"}, int'(stat_o), st);
    chk({tag, " hiz"}, int'(hiz_o), hz);
    chk({tag, " pin"}, int'(fault_n_o), int'(pin));
  endtask

  task automatic pulse_clr();
    @(negedge clk) clr_i = 1;
    @(negedge clk) clr_i = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    outs("R2 in reset", mk(0,1,0,0,0,0,0,0), 'hF, 1);
    rst_n = 1;
    @(negedge clk);
    outs("R2 after reset", mk(0,1,0,0,0,0,0,0), 0, 1);
    pulse_clr();
    outs("R2 por cleared", 0, 0, 1);
  endtask

  task automatic t_uv();
    @(negedge clk) uv_i = 1;
    outs("R1 uv on", mk(1,0,0,0,0,0,0,0), 'hF, 0);
    @(negedge clk) uv_i = 0;
    outs("R1 uv auto", 0, 0, 1);
  endtask

  task automatic t_ov();
    @(negedge clk) ov_hi_i = 1;
    outs("R3 hi ignored when lo sel", 0, 0, 1);
    ov_hi_i = 0; ov_lo_i = 1;
    outs("R3 lo sel", mk(0,0,1,0,0,0,0,0), 'hF, 0);
    cfg_ov_hi_sel = 1;
    outs("R3 lo ignored when hi sel", 0, 0, 1);
    ov_hi_i = 1;
    outs("R3 hi sel", mk(0,0,1,0,0,0,0,0), 'hF, 0);
    @(negedge clk) begin ov_hi_i = 0; ov_lo_i = 0; cfg_ov_hi_sel = 0; end
    outs("R3 auto", 0, 0, 1);
  endtask

  task automatic t_oc();
    @(negedge clk) oc_i = 4'b0010;
    outs("R4 R5 oc pin off", mk(0,0,0,0,0,2,0,0), 2, 1);
    @(negedge clk) oc_i = 0;
    outs("R4 oc latched", mk(0,0,0,0,0,2,0,0), 2, 1);
    cfg_oc_pin_en = 1;
    outs("R5 oc pin on", mk(0,0,0,0,0,2,0,0), 2, 0);
    pulse_clr();
    outs("R4 oc cleared", 0, 0, 1);
    cfg_oc_pin_en = 0;
  endtask

  task automatic t_clr_present();
    @(negedge clk) oc_i = 4'b0001;
    @(negedge clk) clr_i = 1;
    @(negedge clk) begin clr_i = 0; oc_i = 0; end
    outs("R12 clear while present", mk(0,0,0,0,0,1,0,0), 1, 1);
    pulse_clr();
    outs("R12 later clear", 0, 0, 1);
  endtask

  task automatic t_ola();
    @(negedge clk) ola_i = 4'b0100;
    outs("R6 R7 ola pin", mk(0,0,0,0,0,0,4,0), 4, 0);
    @(negedge clk) ola_i = 0;
    outs("R6 ola latched", mk(0,0,0,0,0,0,4,0), 4, 0);
    cfg_ol_keep_run = 1;
    outs("R7 keep running", mk(0,0,0,0,0,0,4,0), 0, 0);
    cfg_ol_pin_mask = 1;
    outs("R6 pin masked", mk(0,0,0,0,0,0,4,0), 0, 1);
    pulse_clr();
    outs("R6 ola cleared", 0, 0, 1);
    cfg_ol_keep_run = 0; cfg_ol_pin_mask = 0;
  endtask

  task automatic t_olp();
    @(negedge clk) olp_i = 4'b1000;
    outs("R8 olp on", mk(0,0,0,0,0,0,0,8), 0, 0);
    @(negedge clk) olp_i = 0;
    outs("R8 olp latched", mk(0,0,0,0,0,0,0,8), 0, 0);
    pulse_clr();
    outs("R8 clear without sequence", mk(0,0,0,0,0,0,0,8), 0, 0);
    @(negedge clk) olp_seq_done_i = 1;
    @(negedge clk) olp_seq_done_i = 0;
    outs("R8 sequence alone", mk(0,0,0,0,0,0,0,8), 0, 0);
    pulse_clr();
    outs("R8 olp cleared", 0, 0, 1);
  endtask

  task automatic t_otw();
    @(negedge clk) otw_i = 1;
    outs("R9 warn status only", mk(0,0,0,1,0,0,0,0), 0, 1);
    cfg_otw_pin_en = 1;
    outs("R9 warn on pin", mk(0,0,0,1,0,0,0,0), 0, 0);
    @(negedge clk) otw_i = 0;
    outs("R9 warn auto", 0, 0, 1);
    cfg_otw_pin_en = 0;
  endtask

  task automatic t_otsd();
    @(negedge clk) otsd_i = 1;
    outs("R10 shutdown", mk(0,0,0,0,1,0,0,0), 'hF, 0);
    @(negedge clk) otsd_i = 0;
    outs("R10 auto", 0, 0, 1);
  endtask

  task automatic t_mix();
    @(negedge clk) begin otw_i = 1; oc_i = 4'b0100; end
    outs("R11 or of bits", mk(0,0,0,1,0,4,0,0), 4, 1);
    @(negedge clk) begin otw_i = 0; oc_i = 0; end
    pulse_clr();
    outs("R11 all clear", 0, 0, 1);
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_uv();
    t_ov();
    t_oc();
    t_clr_present();
    t_ola();
    t_olp();
    t_otw();
    t_otsd();
    t_mix();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule